// File: doc/BRIEF.md
# Windowed Register File

This block holds the integer registers of a RISC core whose visible register set slides along a circular stack of physical registers. At any time the core addresses 32 registers: eight globals that never move, and 24 windowed registers split into an outgoing group, a local group and an incoming group. A procedure call slides the visible window by 16 physical registers, so the caller's outgoing group becomes the callee's incoming group and the callee receives eight fresh locals. A return slides the window back.

The block has two combinational read ports and one write port that commits on the rising clock edge. It keeps a current window pointer and a count of windows in use. If a call arrives while every window is in use, or a return arrives while only one window is in use, the block raises a one-cycle flag and leaves the pointer unchanged. Saving and restoring windows to memory is left to the surrounding core, which observes the flags.

Top module: `windowed_regfile`

## Requirements
- R1: A synchronous reset sets the window pointer to 0, clears both flags and sets the count of windows in use to 1, so a return issued right after reset raises the underflow flag.
- R2: Register index 0 always reads as zero on both read ports, and a write to index 0 has no effect.
- R3: Indices 1 to 7 are global registers: a value written there reads back unchanged from every window.
- R4: A call that does not overflow sets the pointer to (pointer - 1) modulo NWINDOWS on the next edge, and a value the caller wrote to index 8+k (outgoing, k = 0..7) reads back from the callee at index 24+k (incoming).
- R5: Locals (indices 16 to 23) are private to a window: values the callee writes to its locals do not change the caller's locals.
- R6: A return that does not underflow sets the pointer to (pointer + 1) modulo NWINDOWS, restoring the caller's view, including values the callee left in its incoming group, which the caller sees in its outgoing group.
- R7: A call while NWINDOWS windows are in use sets the overflow flag high for exactly the following cycle and leaves the pointer unchanged.
- R8: A return while one window is in use sets the underflow flag high for exactly the following cycle and leaves the pointer unchanged.
- R9: A write issued in the same cycle as a call or return lands in the window that was visible before the move.
- R10: A read of a register in the cycle it is written returns the previous value; the new value is visible after the edge.
- R11: When call and return are asserted in the same cycle, the call is performed and the return is ignored.
- R12: The window stack is circular: from window 0 a call moves to window NWINDOWS-1, whose incoming group is window 0's outgoing group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural index written |
| wr_data | input | DATA_W | Write data |
| rd_idx_a | input | 5 | Read port A index |
| rd_data_a | output | DATA_W | Read port A data, combinational |
| rd_idx_b | input | 5 | Read port B index |
| rd_data_b | output | DATA_W | Read port B data, combinational |
| win_call | input | 1 | Slide the window for a procedure call |
| win_ret | input | 1 | Slide the window back for a return |
| cur_win | output | $clog2(NWINDOWS) | Current window pointer |
| win_ovf | output | 1 | One-cycle overflow flag |
| win_unf | output | 1 | One-cycle underflow flag |

## Verification
The assertions assume that call and return are single-cycle requests sampled on the rising edge, and that the core never relies on a window pointer move while reset is high. They also assume the count of windows in use only changes through these requests. The directed stimulus drives every input on the falling edge, holds each request for exactly one cycle, and always brings the block back to window 0 with one window in use before the next scenario starts, so the expected pointer and flag values follow from the request sequence alone.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
   localparam int IDX_W      = 5;
   localparam int NUM_GLOBAL = 8;
   localparam int WIN_SLIDE  = 16;
   localparam int GIDX_W     = 3;

   typedef enum logic [1:0] {
      GRP_GLOBAL = 2'd0,
      GRP_OUT    = 2'd1,
      GRP_LOCAL  = 2'd2,
      GRP_IN     = 2'd3
   } reg_group_e;

   function automatic reg_group_e group_of(input logic [IDX_W-1:0] idx);
      return reg_group_e'(idx[4:3]);
   endfunction
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
   import wrf_pkg::*;
#(
   parameter int NWINDOWS = 8,
   localparam int CWP_W   = $clog2(NWINDOWS),
   localparam int PA_W    = CWP_W + 4
) (
   input  logic [CWP_W-1:0]  cwp,
   input  logic [IDX_W-1:0]  idx,
   output logic              is_global,
   output logic [GIDX_W-1:0] gidx,
   output logic [PA_W-1:0]   paddr
);
   localparam int SUM_W = PA_W + 1;
   localparam int SPAN  = WIN_SLIDE * NWINDOWS;

   logic [SUM_W-1:0] base;
   logic [SUM_W-1:0] offset;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] wrapped;

   always_comb begin
      is_global = (group_of(idx) == GRP_GLOBAL);
      gidx      = idx[GIDX_W-1:0];
      base      = SUM_W'({cwp, 4'b0000});
      offset    = SUM_W'(idx - IDX_W'(NUM_GLOBAL));
      sum       = base + offset;
      if (sum >= SUM_W'(SPAN)) wrapped = sum - SUM_W'(SPAN);
      else                     wrapped = sum;
      paddr     = wrapped[PA_W-1:0];
   end
endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl #(
   parameter int NWINDOWS = 8,
   localparam int CWP_W   = $clog2(NWINDOWS),
   localparam int CNT_W   = $clog2(NWINDOWS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             call_req,
   input  logic             ret_req,
   output logic [CWP_W-1:0] cwp,
   output logic [CNT_W-1:0] in_use,
   output logic             ovf,
   output logic             unf
);
   localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWINDOWS - 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NWINDOWS);

   logic [CWP_W-1:0] cwp_dn, cwp_up;
   logic             do_call, do_ret, call_blocked, ret_blocked;

   always_comb begin
      cwp_dn       = (cwp == '0) ? LAST_WIN : cwp - 1'b1;
      cwp_up       = (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
      call_blocked = call_req && (in_use == FULL_CNT);
      ret_blocked  = !call_req && ret_req && (in_use == CNT_W'(1));
      do_call      = call_req && !call_blocked;
      do_ret       = !call_req && ret_req && !ret_blocked;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cwp    <= '0;
         in_use <= CNT_W'(1);
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         ovf <= call_blocked;
         unf <= ret_blocked;
         if (do_call) begin
            cwp    <= cwp_dn;
            in_use <= in_use + 1'b1;
         end else if (do_ret) begin
            cwp    <= cwp_up;
            in_use <= in_use - 1'b1;
         end
      end
   end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage
   import wrf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NWINDOWS = 8,
   parameter int NRD      = 2,
   localparam int PA_W    = $clog2(NWINDOWS) + 4,
   localparam int DEPTH   = WIN_SLIDE * NWINDOWS
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic                        w_global,
   input  logic [GIDX_W-1:0]           w_gidx,
   input  logic [PA_W-1:0]             w_paddr,
   input  logic [DATA_W-1:0]           w_data,
   input  logic [NRD-1:0]              r_global,
   input  logic [NRD-1:0][GIDX_W-1:0]  r_gidx,
   input  logic [NRD-1:0][PA_W-1:0]    r_paddr,
   output logic [NRD-1:0][DATA_W-1:0]  r_data
);
   logic [DATA_W-1:0] glob [NUM_GLOBAL];
   logic [DATA_W-1:0] wmem [DEPTH];

   assign glob[0] = '0;

   for (genvar g = 1; g < NUM_GLOBAL; g++) begin : g_glob
      always_ff @(posedge clk) begin
         if (wr_en && w_global && (w_gidx == GIDX_W'(g)))
            glob[g] <= w_data;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !w_global)
         wmem[w_paddr] <= w_data;
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         if (r_global[p]) r_data[p] = glob[r_gidx[p]];
         else             r_data[p] = wmem[r_paddr[p]];
      end
   end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
   import wrf_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NWINDOWS = 8,
   localparam int CWP_W   = $clog2(NWINDOWS),
   localparam int CNT_W   = $clog2(NWINDOWS + 1),
   localparam int PA_W    = CWP_W + 4,
   localparam int NRD     = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [4:0]        wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [4:0]        rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [4:0]        rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              win_call,
   input  logic              win_ret,
   output logic [CWP_W-1:0]  cur_win,
   output logic              win_ovf,
   output logic              win_unf
);
   if (NWINDOWS < 2 || NWINDOWS > 32) begin : g_bad_nwin
      $error("NWINDOWS must lie in 2..32");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic [CNT_W-1:0]             valid_cnt;
   logic                         w_global;
   logic [GIDX_W-1:0]            w_gidx;
   logic [PA_W-1:0]              w_paddr;
   logic [NRD-1:0][IDX_W-1:0]    r_idx;
   logic [NRD-1:0]               r_global;
   logic [NRD-1:0][GIDX_W-1:0]   r_gidx;
   logic [NRD-1:0][PA_W-1:0]     r_paddr;
   logic [NRD-1:0][DATA_W-1:0]   r_data;

   assign r_idx[0]  = rd_idx_a;
   assign r_idx[1]  = rd_idx_b;
   assign rd_data_a = r_data[0];
   assign rd_data_b = r_data[1];

   wrf_window_ctrl #(.NWINDOWS(NWINDOWS)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .call_req (win_call),
      .ret_req  (win_ret),
      .cwp      (cur_win),
      .in_use   (valid_cnt),
      .ovf      (win_ovf),
      .unf      (win_unf)
   );

   wrf_addr_map #(.NWINDOWS(NWINDOWS)) u_wmap (
      .cwp       (cur_win),
      .idx       (wr_idx),
      .is_global (w_global),
      .gidx      (w_gidx),
      .paddr     (w_paddr)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_rmap
      wrf_addr_map #(.NWINDOWS(NWINDOWS)) u_rmap (
         .cwp       (cur_win),
         .idx       (r_idx[p]),
         .is_global (r_global[p]),
         .gidx      (r_gidx[p]),
         .paddr     (r_paddr[p])
      );
   end

   wrf_storage #(.DATA_W(DATA_W), .NWINDOWS(NWINDOWS), .NRD(NRD)) u_store (
      .clk      (clk),
      .wr_en    (wr_en),
      .w_global (w_global),
      .w_gidx   (w_gidx),
      .w_paddr  (w_paddr),
      .w_data   (wr_data),
      .r_global (r_global),
      .r_gidx   (r_gidx),
      .r_paddr  (r_paddr),
      .r_data   (r_data)
   );
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
   parameter int DATA_W   = 32,
   parameter int NWINDOWS = 8,
   localparam int CWP_W   = $clog2(NWINDOWS),
   localparam int CNT_W   = $clog2(NWINDOWS + 1)
) (
   input logic              clk,
   input logic              rst,
   input logic              win_call,
   input logic              win_ret,
   input logic [CWP_W-1:0]  cur_win,
   input logic [CNT_W-1:0]  valid_cnt,
   input logic              win_ovf,
   input logic              win_unf,
   input logic [4:0]        rd_idx_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [4:0]        rd_idx_b,
   input logic [DATA_W-1:0] rd_data_b
);
   function automatic logic [CWP_W-1:0] step_down(input logic [CWP_W-1:0] w);
      return (w == '0) ? CWP_W'(NWINDOWS - 1) : w - 1'b1;
   endfunction
   function automatic logic [CWP_W-1:0] step_up(input logic [CWP_W-1:0] w);
      return (w == CWP_W'(NWINDOWS - 1)) ? '0 : w + 1'b1;
   endfunction

   p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_idx_a == 5'd0) |-> (rd_data_a == '0));
   p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
      (rd_idx_b == 5'd0) |-> (rd_data_b == '0));
   p_count_range_r7: assert property (@(posedge clk) disable iff (rst)
      (valid_cnt >= CNT_W'(1)) && (valid_cnt <= CNT_W'(NWINDOWS)));
   p_call_step_r4: assert property (@(posedge clk) disable iff (rst)
      (win_call && valid_cnt < CNT_W'(NWINDOWS)) |=>
         (cur_win == step_down($past(cur_win))) && !win_ovf);
   p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
      (win_call && valid_cnt == CNT_W'(NWINDOWS)) |=> (win_ovf && $stable(cur_win)));
   p_ret_step_r6: assert property (@(posedge clk) disable iff (rst)
      (win_ret && !win_call && valid_cnt > CNT_W'(1)) |=>
         (cur_win == step_up($past(cur_win))) && !win_unf);
   p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
      (win_ret && !win_call && valid_cnt == CNT_W'(1)) |=> (win_unf && $stable(cur_win)));
   p_call_wins_r11: assert property (@(posedge clk) disable iff (rst)
      (win_call && win_ret) |=> !win_unf);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      (!win_call && !win_ret) |=> (!win_ovf && !win_unf && $stable(cur_win)));
endmodule

bind windowed_regfile wrf_checker #(.DATA_W(DATA_W), .NWINDOWS(NWINDOWS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .win_call  (win_call),
   .win_ret   (win_ret),
   .cur_win   (cur_win),
   .valid_cnt (valid_cnt),
   .win_ovf   (win_ovf),
   .win_unf   (win_unf),
   .rd_idx_a  (rd_idx_a),
   .rd_data_a (rd_data_a),
   .rd_idx_b  (rd_idx_b),
   .rd_data_b (rd_data_b)
);

// File: tb/windowed_regfile_test.sv
module windowed_regfile_test;
   localparam int DW = 32;
   localparam int NW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [4:0]    wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [4:0]    rd_idx_a = '0;
   logic [DW-1:0] rd_data_a;
   logic [4:0]    rd_idx_b = '0;
   logic [DW-1:0] rd_data_b;
   logic          win_call = 1'b0;
   logic          win_ret = 1'b0;
   logic [2:0]    cur_win;
   logic          win_ovf;
   logic          win_unf;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   windowed_regfile #(.DATA_W(DW), .NWINDOWS(NW)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
      .win_call(win_call), .win_ret(win_ret), .cur_win(cur_win),
      .win_ovf(win_ovf), .win_unf(win_unf)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one cycle: inputs set at the falling edge, held across one rising edge
   task automatic cyc(input logic c, input logic r, input logic we,
                      input logic [4:0] idx, input logic [DW-1:0] d);
      @(negedge clk);
      win_call = c; win_ret = r; wr_en = we; wr_idx = idx; wr_data = d;
      @(posedge clk);
      #1;
      win_call = 0; win_ret = 0; wr_en = 0;
   endtask

   task automatic wr(input logic [4:0] idx, input logic [DW-1:0] d);
      cyc(0, 0, 1, idx, d);
   endtask

   function automatic logic [DW-1:0] rd(input logic [4:0] idx);
      return '0;
   endfunction

   task automatic read_a(input logic [4:0] idx, output logic [DW-1:0] v);
      rd_idx_a = idx;
      #1;
      v = rd_data_a;
   endtask

   task automatic t_reset();
      logic [DW-1:0] v;
      check("R1 cur_win after reset", 32'(cur_win), 0);
      check("R1 ovf after reset", 32'(win_ovf), 0);
      check("R1 unf after reset", 32'(win_unf), 0);
      cyc(0, 1, 0, 0, 0);
      check("R1 return after reset underflows", 32'(win_unf), 1);
      check("R1 pointer held", 32'(cur_win), 0);
      read_a(0, v);
      check("R2 r0 reads zero", v, 0);
   endtask

   task automatic t_zero();
      logic [DW-1:0] v;
      wr(0, 32'hFFFF_FFFF);
      read_a(0, v);
      check("R2 r0 write ignored port a", v, 0);
      rd_idx_b = 0;
      #1;
      check("R2 r0 write ignored port b", rd_data_b, 0);
   endtask

   task automatic t_globals();
      logic [DW-1:0] v;
      for (int g = 1; g < 8; g++) wr(5'(g), 32'h600 + 32'(g));
      cyc(1, 0, 0, 0, 0);
      check("R3 moved window", 32'(cur_win), 7);
      for (int g = 1; g < 8; g++) begin
         read_a(5'(g), v);
         check("R3 global in callee", v, 32'h600 + 32'(g));
      end
      cyc(0, 1, 0, 0, 0);
      read_a(5, v);
      check("R3 global after return", v, 32'h605);
   endtask

   task automatic t_call_share();
      logic [DW-1:0] v;
      wr(8, 32'hA0);
      wr(15, 32'hA7);
      wr(16, 32'h10C0);
      cyc(1, 0, 0, 0, 0);
      check("R12 call from window 0 wraps", 32'(cur_win), 7);
      read_a(24, v);
      check("R4 outgoing r8 seen as incoming r24", v, 32'hA0);
      read_a(31, v);
      check("R4 outgoing r15 seen as incoming r31", v, 32'hA7);
      wr(16, 32'h77C0);
      read_a(16, v);
      check("R5 callee local written", v, 32'h77C0);
      wr(24, 32'hBEEF);
      cyc(0, 1, 0, 0, 0);
      check("R6 return restores pointer", 32'(cur_win), 0);
      read_a(16, v);
      check("R5 caller local untouched", v, 32'h10C0);
      read_a(8, v);
      check("R6 callee result in caller r8", v, 32'hBEEF);
   endtask

   task automatic t_same_cycle_rw();
      wr(17, 32'h5);
      @(negedge clk);
      rd_idx_a = 17; wr_en = 1; wr_idx = 17; wr_data = 32'h11;
      #2;
      check("R10 old value during write", rd_data_a, 32'h5);
      @(posedge clk);
      #1;
      wr_en = 0;
      check("R10 new value after edge", rd_data_a, 32'h11);
   endtask

   task automatic t_write_with_move();
      logic [DW-1:0] v;
      cyc(1, 0, 1, 18, 32'hCC);
      check("R9 call performed", 32'(cur_win), 7);
      wr(18, 32'hDD);
      cyc(0, 1, 1, 19, 32'hEE);
      check("R9 return performed", 32'(cur_win), 0);
      read_a(18, v);
      check("R9 write with call hit caller window", v, 32'hCC);
      read_a(19, v);
      check("R9 write with return missed caller window", v === 32'hEE ? 32'h1 : 32'h0, 0);
      cyc(1, 0, 0, 0, 0);
      read_a(19, v);
      check("R9 write with return hit callee window", v, 32'hEE);
      read_a(18, v);
      check("R9 callee local kept", v, 32'hDD);
      cyc(0, 1, 0, 0, 0);
   endtask

   task automatic t_both();
      cyc(1, 1, 0, 0, 0);
      check("R11 call wins", 32'(cur_win), 7);
      check("R11 no underflow", 32'(win_unf), 0);
      cyc(0, 1, 0, 0, 0);
      check("R11 back to window 0", 32'(cur_win), 0);
   endtask

   task automatic t_overflow();
      for (int i = 0; i < NW - 1; i++) cyc(1, 0, 0, 0, 0);
      check("R4 pointer after seven calls", 32'(cur_win), 1);
      check("R7 no overflow yet", 32'(win_ovf), 0);
      cyc(1, 0, 0, 0, 0);
      check("R7 overflow flag", 32'(win_ovf), 1);
      check("R7 pointer held", 32'(cur_win), 1);
      cyc(0, 0, 0, 0, 0);
      check("R7 overflow one cycle", 32'(win_ovf), 0);
      for (int i = 0; i < NW - 1; i++) cyc(0, 1, 0, 0, 0);
      check("R6 pointer after seven returns", 32'(cur_win), 0);
      check("R8 no underflow yet", 32'(win_unf), 0);
      cyc(0, 1, 0, 0, 0);
      check("R8 underflow flag", 32'(win_unf), 1);
      check("R8 pointer held", 32'(cur_win), 0);
      cyc(0, 0, 0, 0, 0);
      check("R8 underflow one cycle", 32'(win_unf), 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      #1;
      t_reset();
      t_zero();
      t_globals();
      t_call_share();
      t_same_cycle_rw();
      t_write_with_move();
      t_both();
      t_overflow();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule